// File: doc/BRIEF.md
# Display Window Update Sequencer

This block turns a single request for a rectangular update of a display controller's frame memory into the byte stream that such a controller expects on its serial command link. Given the rectangle's inclusive corners, it adds the fixed panel offsets to the corners and sends the column-range command, the row-range command and the memory-write command. It then streams the pixel bytes, two per RGB565 pixel, drawn from a 16-bit pixel input. Every byte leaves through a byte-wide valid/ready port that carries a data/command tag, so a serial link transmitter downstream can place the tag on its own wire or in a ninth bit.

A blank request ignores the rectangle inputs, sets the window to the whole panel, and sends zero pixel bytes without taking anything from the pixel input. A byte-swap control, sampled with the start request, chooses which half of each pixel goes first. A one-cycle done pulse marks the acceptance of the final byte. A start request that arrives during a sequence is dropped.

Top module: `dcs_window_seq`

## Requirements
- R1: After a start in idle, the bytes leave in this order: command 0x2A, four column bytes, command 0x2B, four row bytes, command 0x2C, then the pixel bytes.
- R2: The four column bytes are, in order, the high and low bytes of (x start + LEFT_OFS), then the high and low bytes of (x end + LEFT_OFS). The end is inclusive.
- R3: The four row bytes follow the R2 layout for (y start + TOP_OFS) and (y end + TOP_OFS).
- R4: The three command bytes carry dc = 0. Every parameter and pixel byte carries dc = 1.
- R5: Exactly (x end − x start + 1) × (y end − y start + 1) × 2 pixel bytes follow 0x2C. One pixel is taken per pix_valid_i/pix_ready_o handshake, in arrival order.
- R6: With swap_i low at start, pixel bits [15:8] go before bits [7:0]. With swap_i high, bits [7:0] go first.
- R7: In blank mode the window is columns 0..PANEL_W−1 and rows 0..PANEL_H−1, with offsets added as in R2/R3. All pixel bytes are 0x00, and pix_ready_o stays low.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o and out_dc_o hold their values into the next cycle.
- R9: done_o is high for exactly the one cycle after the final pixel byte is accepted. busy_o is low from that cycle on.
- R10: A start, or a change to the rectangle, blank or swap inputs, while busy_o is high has no effect on the stream in progress and starts no new one.
- R11: During and straight after reset, out_valid_o, busy_o, done_o and pix_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one update; honoured only when idle |
| blank_i | input | 1 | With start: fill the full panel with zero pixels |
| swap_i | input | 1 | With start: send the low pixel byte first |
| x_start_i | input | 16 | First column of the rectangle |
| x_end_i | input | 16 | Last column, inclusive |
| y_start_i | input | 16 | First row of the rectangle |
| y_end_i | input | 16 | Last row, inclusive |
| pix_valid_i | input | 1 | Pixel word available |
| pix_data_i | input | 16 | RGB565 pixel word |
| pix_ready_o | output | 1 | Pixel word taken this cycle when valid |
| out_valid_o | output | 1 | Byte on out_data_o is valid |
| out_data_o | output | 8 | Command or parameter byte |
| out_dc_o | output | 1 | 0 = command byte, 1 = parameter byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The offsets are chosen so that adding them carries into the high address byte. A sequencer that split the coordinates before adding the offset, or that dropped the carry, would send a wrong high byte in the window commands. Runs with and without byte swap, with stalled pixel input and with irregular backpressure expose a design that reorders a pixel's bytes, loses or repeats a byte under stall, or changes a held byte. A blank run catches a design that draws pixels from the input or sizes the window wrongly. A start pulse during an active run, followed by a quiet window after done, catches a design that restarts, and a final byte miscount shows up as extra bytes or a missing or mistimed done pulse.

// File: rtl/dcs_window_seq.sv
module dcs_window_seq #(
  parameter int PANEL_W  = 240,
  parameter int PANEL_H  = 320,
  parameter int LEFT_OFS = 0,
  parameter int TOP_OFS  = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        blank_i,
  input  logic        swap_i,
  input  logic [15:0] x_start_i,
  input  logic [15:0] x_end_i,
  input  logic [15:0] y_start_i,
  input  logic [15:0] y_end_i,
  input  logic        pix_valid_i,
  input  logic [15:0] pix_data_i,
  output logic        pix_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_dc_o,
  input  logic        out_ready_i,
  output logic        done_o,
  output logic        busy_o
);
  localparam logic [7:0] CMD_COL  = 8'h2A;
  localparam logic [7:0] CMD_PAGE = 8'h2B;
  localparam logic [7:0] CMD_MEM  = 8'h2C;
  localparam logic [3:0] HDR_LAST = 4'd10;
  localparam int         CNT_W    = 35;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PIX, S_DRAIN} st_t;

  st_t              st;
  logic [3:0]       idx;
  logic [15:0]      xs, xe, ys, ye;
  logic             blank_q, swap_q, half, out_last;
  logic [7:0]       pend, hdr_byte;
  logic [CNT_W-1:0] left;

  wire slot = !out_valid_o || out_ready_i;

  wire [15:0] x0 = blank_i ? 16'd0 : x_start_i;
  wire [15:0] x1 = blank_i ? 16'(PANEL_W - 1) : x_end_i;
  wire [15:0] y0 = blank_i ? 16'd0 : y_start_i;
  wire [15:0] y1 = blank_i ? 16'(PANEL_H - 1) : y_end_i;
  wire [16:0] w17 = {1'b0, x1} - {1'b0, x0} + 17'd1;
  wire [16:0] h17 = {1'b0, y1} - {1'b0, y0} + 17'd1;
  wire [33:0] npix = w17 * h17;

  wire hdr_dc = !(idx == 4'd0 || idx == 4'd5 || idx == HDR_LAST);

  always_comb begin
    case (idx)
      4'd0:    hdr_byte = CMD_COL;
      4'd1:    hdr_byte = xs[15:8];
      4'd2:    hdr_byte = xs[7:0];
      4'd3:    hdr_byte = xe[15:8];
      4'd4:    hdr_byte = xe[7:0];
      4'd5:    hdr_byte = CMD_PAGE;
      4'd6:    hdr_byte = ys[15:8];
      4'd7:    hdr_byte = ys[7:0];
      4'd8:    hdr_byte = ye[15:8];
      4'd9:    hdr_byte = ye[7:0];
      default: hdr_byte = CMD_MEM;
    endcase
  end

  assign busy_o      = (st != S_IDLE);
  assign pix_ready_o = (st == S_PIX) && !blank_q && !half && slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; half <= 1'b0; pend <= '0; left <= '0;
      xs <= '0; xe <= '0; ys <= '0; ye <= '0;
      blank_q <= 1'b0; swap_q <= 1'b0; out_last <= 1'b0;
      out_valid_o <= 1'b0; out_data_o <= '0; out_dc_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (out_valid_o && out_ready_i) begin
        out_valid_o <= 1'b0;
        if (out_last) begin
          out_last <= 1'b0;
          done_o   <= 1'b1;
          st       <= S_IDLE;
        end
      end
      case (st)
        S_IDLE: if (start_i) begin
          xs <= x0 + 16'(LEFT_OFS); xe <= x1 + 16'(LEFT_OFS);
          ys <= y0 + 16'(TOP_OFS);  ye <= y1 + 16'(TOP_OFS);
          left <= {npix, 1'b0};
          blank_q <= blank_i; swap_q <= swap_i;
          idx <= '0; half <= 1'b0;
          st <= S_HDR;
        end
        S_HDR: if (slot) begin
          out_valid_o <= 1'b1;
          out_data_o  <= hdr_byte;
          out_dc_o    <= hdr_dc;
          idx         <= idx + 4'd1;
          if (idx == HDR_LAST) st <= S_PIX;
        end
        S_PIX: if (slot) begin
          if (half) begin
            out_valid_o <= 1'b1; out_data_o <= pend; out_dc_o <= 1'b1;
            half <= 1'b0; left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
              out_last <= 1'b1;
              st <= S_DRAIN;
            end
          end else if (blank_q) begin
            out_valid_o <= 1'b1; out_data_o <= 8'h00; out_dc_o <= 1'b1;
            pend <= 8'h00; half <= 1'b1; left <= left - 1'b1;
          end else if (pix_valid_i) begin
            out_valid_o <= 1'b1; out_dc_o <= 1'b1;
            out_data_o  <= swap_q ? pix_data_i[7:0] : pix_data_i[15:8];
            pend        <= swap_q ? pix_data_i[15:8] : pix_data_i[7:0];
            half <= 1'b1; left <= left - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_dc_o));

  a_r4_cmd_codes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_dc_o |-> (out_data_o == CMD_COL || out_data_o == CMD_PAGE || out_data_o == CMD_MEM));

  a_r9_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && out_last |=> done_o && !busy_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !out_valid_o && !pix_ready_o);

  a_r7_blank_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && blank_q |-> !pix_ready_o);
endmodule

// File: tb/dcs_window_seq_tb_top.sv
`timescale 1ns/1ps
module dcs_window_seq_tb_top;
  localparam int PW = 6, PH = 3, LO = 250, TOP = 300;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 0, blank_i = 0, swap_i = 0;
  logic [15:0] x_start_i = 0, x_end_i = 0, y_start_i = 0, y_end_i = 0;
  logic        pix_valid_i = 0;
  logic [15:0] pix_data_i = 0;
  logic        pix_ready_o, out_valid_o, out_dc_o, done_o, busy_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i = 1'b1;

  dcs_window_seq #(.PANEL_W(PW), .PANEL_H(PH), .LEFT_OFS(LO), .TOP_OFS(TOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blank_i(blank_i), .swap_i(swap_i),
    .x_start_i(x_start_i), .x_end_i(x_end_i), .y_start_i(y_start_i), .y_end_i(y_end_i),
    .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_ready_o(pix_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_dc_o(out_dc_o),
    .out_ready_i(out_ready_i), .done_o(done_o), .busy_o(busy_o));

  always #2.5 clk = ~clk;

  logic [8:0] q[$];
  string      tq[$];
  int n_chk = 0, n_fail = 0, cyc = 0, npix = 0, k = 0;
  bit rdy_mode = 0, gap_mode = 0, blank_run = 0, exp_done = 0, done_seen = 0;
  bit hold_pend = 0, f = 0;
  logic [8:0] hold_v;
  logic [15:0] seed = 16'h0;

  function automatic logic [15:0] pixval(int i);
    return seed + 16'(i * 4951);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(bit dc, logic [7:0] d, string tag);
    q.push_back({dc, d});
    tq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid_o && {out_dc_o, out_data_o} == hold_v, "R8 held byte changed",
            {23'd0, out_dc_o, out_data_o}, {23'd0, hold_v});
      hold_pend = out_valid_o && !out_ready_i;
      hold_v    = {out_dc_o, out_data_o};
      if (exp_done) begin
        chk(done_o == 1'b1, "R9 done pulse", {31'd0, done_o}, 32'd1);
        chk(busy_o == 1'b0, "R9 busy after done", {31'd0, busy_o}, 32'd0);
        if (done_o) done_seen = 1;
        exp_done = 0;
      end else if (done_o) begin
        chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
      end
      if (blank_run)
        chk(!pix_ready_o, "R7 pixel requested in blank mode", {31'd0, pix_ready_o}, 32'd0);
      if (out_valid_o && out_ready_i) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected byte", {23'd0, out_dc_o, out_data_o}, 32'd0);
        end else begin
          logic [8:0] e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          chk({out_dc_o, out_data_o} == e, t, {23'd0, out_dc_o, out_data_o}, {23'd0, e});
          if (q.size() == 0) exp_done = 1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      if (f) k++;
      pix_data_i  = pixval(k);
      pix_valid_i = (k < npix) && !blank_run && !(gap_mode && (cyc % 4 == 1));
      out_ready_i = rdy_mode ? (cyc % 3 != 0) : 1'b1;
      @(negedge clk);
      f = pix_valid_i && pix_ready_o;
    end
  end

  task automatic run(int xs, int xe, int ys, int ye, bit bl, bit sw, bit rdy, bit gap, bit extra);
    int wx0, wx1, wy0, wy1;
    wx0 = bl ? 0 : xs; wx1 = bl ? PW - 1 : xe;
    wy0 = bl ? 0 : ys; wy1 = bl ? PH - 1 : ye;
    push(0, 8'h2A, "R1 R4 column command");
    push(1, 8'((wx0 + LO) >> 8), "R2 R4 column start high");
    push(1, 8'(wx0 + LO),        "R2 column start low");
    push(1, 8'((wx1 + LO) >> 8), "R2 column end high");
    push(1, 8'(wx1 + LO),        "R2 column end low");
    push(0, 8'h2B, "R1 R4 page command");
    push(1, 8'((wy0 + TOP) >> 8), "R3 row start high");
    push(1, 8'(wy0 + TOP),        "R3 row start low");
    push(1, 8'((wy1 + TOP) >> 8), "R3 row end high");
    push(1, 8'(wy1 + TOP),        "R3 row end low");
    push(0, 8'h2C, "R1 R4 memory write command");
    seed = 16'(xs * 37 + ys * 101 + 16'h1A5);
    for (int i = 0; i < (wx1 - wx0 + 1) * (wy1 - wy0 + 1); i++) begin
      logic [15:0] p;
      p = pixval(i);
      if (bl) begin
        push(1, 8'h00, "R7 zero pixel byte");
        push(1, 8'h00, "R7 zero pixel byte");
      end else if (sw) begin
        push(1, p[7:0],  "R6 R5 swapped first byte");
        push(1, p[15:8], "R6 R5 swapped second byte");
      end else begin
        push(1, p[15:8], "R6 R5 high byte first");
        push(1, p[7:0],  "R6 R5 low byte second");
      end
    end
    @(posedge clk); #1;
    rdy_mode = rdy; gap_mode = gap; blank_run = bl; done_seen = 0;
    k = 0; npix = bl ? 0 : (wx1 - wx0 + 1) * (wy1 - wy0 + 1);
    x_start_i = 16'(xs); x_end_i = 16'(xe); y_start_i = 16'(ys); y_end_i = 16'(ye);
    blank_i = bl; swap_i = sw; start_i = 1;
    @(posedge clk); #1;
    start_i = 0;
    x_start_i = 16'h0033; x_end_i = 16'h0044; y_start_i = 16'h0001; y_end_i = 16'h0009;
    blank_i = !bl; swap_i = !sw;
    if (extra) begin
      repeat (6) @(posedge clk);
      #1 start_i = 1;
      @(posedge clk); #1 start_i = 0;
    end
    for (int t = 0; t < 5000 && !done_seen; t++) @(posedge clk);
    chk(done_seen, "R9 sequence completed", {31'd0, done_seen}, 32'd1);
    chk(q.size() == 0, "R5 all expected bytes sent", q.size(), 32'd0);
    repeat (20) @(posedge clk);
    blank_run = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid_o && !busy_o && !done_o && !pix_ready_o, "R11 reset state",
        {28'd0, out_valid_o, busy_o, done_o, pix_ready_o}, 32'd0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!out_valid_o && !busy_o && !done_o && !pix_ready_o, "R11 state after reset",
        {28'd0, out_valid_o, busy_o, done_o, pix_ready_o}, 32'd0);
    run(0, 1, 0, 1, 0, 0, 0, 0, 0);
    run(4, 7, 2, 2, 0, 1, 1, 1, 0);
    run(0, 0, 0, 0, 1, 0, 1, 0, 0);
    run(9, 9, 5, 5, 0, 0, 0, 0, 1);
    run(3, 5, 10, 13, 0, 0, 1, 1, 1);
    run(1, 2, 0, 1, 0, 1, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule